// File: doc/BRIEF.md
# Page-Table Refill Descriptor Engine

This block loads entries into one of several two-dimensional translation tables by walking a chain of rectangle descriptors held in memory. Software places descriptors and their page-address arrays in memory, then writes the address of the first descriptor into the engine's descriptor register. The engine fetches the descriptor, checks the rectangle, and for every slot of that rectangle reads one 32-bit page address and writes it into the chosen table. It then follows the descriptor's link. When it reaches a null link it flags list completion in the interrupt status register.

A descriptor is five consecutive 32-bit words at a 16-byte aligned address: word 0 is the link to the next descriptor (zero ends the chain), word 1 packs the first corner as {y0[31:16], x0[15:0]}, word 2 packs the last corner as {y1[31:16], x1[15:0]}, word 3 carries the table number in bits [3:0], and word 4 points to the page-address array. Corners are inclusive. Memory is reached through a valid/ready request port with one read in flight at a time. Writing zero to the descriptor register abandons a walk in progress.

Registers (byte offsets): 0x00 descriptor pointer, 0x04 status (bit 0 READY, bit 1 ERR), 0x08 interrupt status (write one to clear), 0x0C interrupt enable, 0x10 hardware info, 0x14 table geometry.

Top module: `ptr_refill_engine`

## Requirements
- R1: After reset the status register reads 0x1 (READY set, ERR clear), interrupt status and enable read 0, `irq` is low and no memory request is issued.
- R2: Offset 0x10 reads the engine count (1) in bits [28:24] and the table count in bits [20:16]; offset 0x14 reads table width/32 in bits [19:16] and table height/32 in bits [27:24]; writes to either leave them unchanged.
- R3: A descriptor is fetched as five word reads at pointer+0, +4, +8, +12, +16, with the pointer's low four bits forced to zero, for both the first pointer and every link.
- R4: Each descriptor writes (1+x1−x0)×(1+y1−y0) entries in raster order, x fastest, taking data words from consecutive addresses starting at the data pointer with its low four bits forced to zero, into the table given by word 3 bits [3:0].
- R5: The engine follows links until a zero link; after the last entry it sets bit 1 (list done) of the interrupt status register and READY returns to 1.
- R6: Writing ones to the interrupt status register clears those bits only; `irq` is high exactly when some status bit has its enable bit (same position, offset 0x0C, bits [7:0], 0x7E enables list done) set.
- R7: A descriptor with x1<x0, y1<y0, x1 or y1 outside the table, or a table number not below the table count, writes no entry, sets ERR, ends the chain without setting list done; the next accepted start clears ERR.
- R8: Writing zero to the descriptor register stops the walk: no table write follows, and READY returns once any read in flight has returned.
- R9: A nonzero descriptor write while READY is 0 is ignored: the running chain finishes unchanged and the new pointer is never fetched.
- R10: At most one memory read is outstanding, and a request held without ready keeps its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt, status AND enable |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tbl_we | output | 1 | Table entry write strobe |
| tbl_id | output | TW | Target table number |
| tbl_x | output | XW | Entry column |
| tbl_y | output | YW | Entry row |
| tbl_data | output | 32 | Page address written |

## Verification
The assertions assume the memory side answers only a request it has accepted, with exactly one response per accepted request, and that a cancel is the only reason a pending request may be withdrawn. The bench memory model answers one cycle after each accepted request and never otherwise, while its ready line stalls on a fixed rotating pattern so that held requests occur. Descriptors placed by the bench always lie inside its memory image, and illegal rectangles are built on purpose only to exercise the error path.

// File: rtl/ptr_refill_pkg.sv
`timescale 1ns/1ps
package ptr_refill_pkg;

  localparam int unsigned DESC_WORDS = 5;
  localparam int unsigned LST_BIT    = 1;
  localparam int unsigned NUM_ENG    = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_CHECK, ST_FREQ, ST_FWAIT, ST_DRAIN
  } walk_state_e;

  typedef struct packed {
    logic [31:0] next_ptr;
    logic [15:0] x0;
    logic [15:0] y0;
    logic [15:0] x1;
    logic [15:0] y1;
    logic [3:0]  tid;
    logic [31:0] data_ptr;
  } desc_t;

  function automatic logic [31:0] align16(logic [31:0] a);
    return {a[31:4], 4'h0};
  endfunction

  function automatic logic area_bad(desc_t d, int unsigned w, int unsigned h,
                                    int unsigned ntab);
    return (d.x1 < d.x0) || (d.y1 < d.y0) ||
           (32'(d.x1) >= w) || (32'(d.y1) >= h) || (32'(d.tid) >= ntab);
  endfunction

  function automatic logic [31:0] hwinfo_word(int unsigned ntab);
    logic [31:0] r;
    r = '0;
    r[28:24] = 5'(NUM_ENG);
    r[20:16] = 5'(ntab);
    return r;
  endfunction

  function automatic logic [31:0] geom_word(int unsigned w, int unsigned h);
    logic [31:0] r;
    r = '0;
    r[19:16] = 4'(w / 32);
    r[27:24] = 4'(h / 32);
    return r;
  endfunction

endpackage

// File: rtl/ptr_raster.sv
`timescale 1ns/1ps
module ptr_raster #(
  parameter int XW = 7,
  parameter int YW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic [XW-1:0] x1,
  input  logic [YW-1:0] y1,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          area_end
);
  logic row_end;
  assign row_end  = (x == x1);
  assign area_end = row_end && (y == y1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= x0;
      y <= y0;
    end else if (step) begin
      if (row_end) begin
        x <= x0;
        y <= y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptr_walker.sv
`timescale 1ns/1ps
module ptr_walker
  import ptr_refill_pkg::*;
#(
  parameter int NUM_TABLES = 2,
  parameter int TBL_W      = 96,
  parameter int TBL_H      = 64,
  parameter int XW         = 7,
  parameter int YW         = 6,
  parameter int TW         = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic [31:0]   start_ptr,
  input  logic          cancel_evt,
  output logic          busy,
  output logic          done_evt,
  output logic          err_evt,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          tbl_we,
  output logic [TW-1:0] tbl_id,
  output logic [XW-1:0] tbl_x,
  output logic [YW-1:0] tbl_y,
  output logic [31:0]   tbl_data
);
  walk_state_e st;
  desc_t       d;
  logic [2:0]  widx;
  logic [31:0] dbase, rd_addr;
  logic        chk_bad, area_end, ras_load, ras_step, rsp_f, req_fire;
  logic        in_wait, in_req;

  assign chk_bad  = area_bad(d, TBL_W, TBL_H, NUM_TABLES);
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_f    = (st == ST_FWAIT) && mem_rsp_valid && !cancel_evt;
  assign in_wait  = (st == ST_DWAIT) || (st == ST_FWAIT);
  assign in_req   = (st == ST_DREQ) || (st == ST_FREQ);
  assign ras_load = (st == ST_CHECK) && !chk_bad && !cancel_evt;
  assign ras_step = rsp_f;

  assign busy          = (st != ST_IDLE);
  assign mem_req_valid = in_req;
  assign mem_req_addr  = (st == ST_DREQ) ? dbase + {27'd0, widx, 2'b00} : rd_addr;
  assign done_evt      = rsp_f && area_end && (d.next_ptr == 32'd0);
  assign err_evt       = (st == ST_CHECK) && chk_bad && !cancel_evt;

  assign tbl_we   = rsp_f;
  assign tbl_id   = d.tid[TW-1:0];
  assign tbl_data = mem_rsp_data;

  ptr_raster #(.XW(XW), .YW(YW)) u_raster (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ras_load),
    .step     (ras_step),
    .x0       (d.x0[XW-1:0]),
    .y0       (d.y0[YW-1:0]),
    .x1       (d.x1[XW-1:0]),
    .y1       (d.y1[YW-1:0]),
    .x        (tbl_x),
    .y        (tbl_y),
    .area_end (area_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      d       <= '0;
      widx    <= '0;
      dbase   <= '0;
      rd_addr <= '0;
    end else if (cancel_evt && busy) begin
      if (in_wait || st == ST_DRAIN)
        st <= mem_rsp_valid ? ST_IDLE : ST_DRAIN;
      else if (in_req && mem_req_ready)
        st <= ST_DRAIN;
      else
        st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start_evt) begin
          dbase <= align16(start_ptr);
          widx  <= '0;
          st    <= ST_DREQ;
        end
        ST_DREQ: if (req_fire) st <= ST_DWAIT;
        ST_DWAIT: if (mem_rsp_valid) begin
          case (widx)
            3'd0: d.next_ptr <= mem_rsp_data;
            3'd1: begin d.x0 <= mem_rsp_data[15:0]; d.y0 <= mem_rsp_data[31:16]; end
            3'd2: begin d.x1 <= mem_rsp_data[15:0]; d.y1 <= mem_rsp_data[31:16]; end
            3'd3: d.tid <= mem_rsp_data[3:0];
            default: d.data_ptr <= mem_rsp_data;
          endcase
          if (widx == 3'(DESC_WORDS - 1)) begin
            st <= ST_CHECK;
          end else begin
            widx <= widx + 1'b1;
            st   <= ST_DREQ;
          end
        end
        ST_CHECK: begin
          if (chk_bad) begin
            st <= ST_IDLE;
          end else begin
            rd_addr <= align16(d.data_ptr);
            st      <= ST_FREQ;
          end
        end
        ST_FREQ: if (req_fire) st <= ST_FWAIT;
        ST_FWAIT: if (mem_rsp_valid) begin
          rd_addr <= rd_addr + 32'd4;
          if (!area_end) begin
            st <= ST_FREQ;
          end else if (d.next_ptr == 32'd0) begin
            st <= ST_IDLE;
          end else begin
            dbase <= align16(d.next_ptr);
            widx  <= '0;
            st    <= ST_DREQ;
          end
        end
        ST_DRAIN: if (mem_rsp_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptr_regs.sv
`timescale 1ns/1ps
module ptr_regs
  import ptr_refill_pkg::*;
#(
  parameter int NUM_TABLES = 2,
  parameter int TBL_W      = 96,
  parameter int TBL_H      = 64,
  parameter int AW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          walker_busy,
  input  logic          done_evt,
  input  logic          err_evt,
  output logic          start_evt,
  output logic          cancel_evt,
  output logic [31:0]   start_ptr,
  output logic [7:0]    irq_st,
  output logic [7:0]    irq_en,
  output logic          irq
);
  localparam logic [AW-1:0] A_DESC   = AW'(0);
  localparam logic [AW-1:0] A_STAT   = AW'(4);
  localparam logic [AW-1:0] A_IRQST  = AW'(8);
  localparam logic [AW-1:0] A_IRQEN  = AW'(12);
  localparam logic [AW-1:0] A_HWINFO = AW'(16);
  localparam logic [AW-1:0] A_GEOM   = AW'(20);

  logic [31:0] desc_q;
  logic        err_q;
  logic        wr_desc;
  logic [7:0]  w1c, set_bits;

  assign wr_desc    = reg_we && (reg_addr == A_DESC);
  assign cancel_evt = wr_desc && (reg_wdata == 32'd0);
  assign start_evt  = wr_desc && (reg_wdata != 32'd0) && !walker_busy;
  assign start_ptr  = reg_wdata;
  assign irq        = |(irq_st & irq_en);

  always_comb begin
    w1c = (reg_we && reg_addr == A_IRQST) ? reg_wdata[7:0] : 8'h00;
    set_bits = 8'h00;
    set_bits[LST_BIT] = done_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
      err_q  <= 1'b0;
      irq_st <= '0;
      irq_en <= '0;
    end else begin
      if (cancel_evt)     desc_q <= '0;
      else if (start_evt) desc_q <= reg_wdata;
      if (start_evt)      err_q <= 1'b0;
      else if (err_evt)   err_q <= 1'b1;
      irq_st <= (irq_st & ~w1c) | set_bits;
      if (reg_we && reg_addr == A_IRQEN) irq_en <= reg_wdata[7:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_DESC:   reg_rdata = desc_q;
      A_STAT:   reg_rdata = {30'd0, err_q, !walker_busy};
      A_IRQST:  reg_rdata = {24'd0, irq_st};
      A_IRQEN:  reg_rdata = {24'd0, irq_en};
      A_HWINFO: reg_rdata = hwinfo_word(NUM_TABLES);
      A_GEOM:   reg_rdata = geom_word(TBL_W, TBL_H);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptr_refill_engine.sv
`timescale 1ns/1ps
module ptr_refill_engine #(
  parameter int NUM_TABLES = 2,
  parameter int TBL_W      = 96,
  parameter int TBL_H      = 64,
  parameter int AW         = 5,
  localparam int XW        = $clog2(TBL_W),
  localparam int YW        = $clog2(TBL_H),
  localparam int TW        = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          tbl_we,
  output logic [TW-1:0] tbl_id,
  output logic [XW-1:0] tbl_x,
  output logic [YW-1:0] tbl_y,
  output logic [31:0]   tbl_data
);
  logic        start_evt, cancel_evt, done_evt, err_evt, busy;
  logic [31:0] start_ptr;
  logic [7:0]  irq_st, irq_en;

  ptr_regs #(.NUM_TABLES(NUM_TABLES), .TBL_W(TBL_W), .TBL_H(TBL_H), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .walker_busy (busy),
    .done_evt    (done_evt),
    .err_evt     (err_evt),
    .start_evt   (start_evt),
    .cancel_evt  (cancel_evt),
    .start_ptr   (start_ptr),
    .irq_st      (irq_st),
    .irq_en      (irq_en),
    .irq         (irq)
  );

  ptr_walker #(.NUM_TABLES(NUM_TABLES), .TBL_W(TBL_W), .TBL_H(TBL_H),
               .XW(XW), .YW(YW), .TW(TW)) u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_evt     (start_evt),
    .start_ptr     (start_ptr),
    .cancel_evt    (cancel_evt),
    .busy          (busy),
    .done_evt      (done_evt),
    .err_evt       (err_evt),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .tbl_we        (tbl_we),
    .tbl_id        (tbl_id),
    .tbl_x         (tbl_x),
    .tbl_y         (tbl_y),
    .tbl_data      (tbl_data)
  );
endmodule

// File: rtl/ptr_refill_chk.sv
`timescale 1ns/1ps
module ptr_refill_chk
  import ptr_refill_pkg::*;
#(
  parameter int NUM_TABLES = 2,
  parameter int TBL_W      = 96,
  parameter int TBL_H      = 64,
  parameter int XW         = 7,
  parameter int YW         = 6,
  parameter int TW         = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [31:0]   mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          tbl_we,
  input logic [TW-1:0] tbl_id,
  input logic [XW-1:0] tbl_x,
  input logic [YW-1:0] tbl_y,
  input logic          busy,
  input logic          cancel_evt,
  input logic          done_evt,
  input logic          err_evt,
  input logic [7:0]    irq_st
);
  logic outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst);  // R10
  AST_RSP_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> outst);  // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !cancel_evt) |=> (mem_req_valid && $stable(mem_req_addr)));  // R10
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));  // R3
  AST_ENTRY_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (32'(tbl_x) < TBL_W && 32'(tbl_y) < TBL_H && 32'(tbl_id) < NUM_TABLES));  // R4
  AST_DONE_FLAGS_LST: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq_st[LST_BIT]);  // R5
  AST_ERR_ENDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !busy);  // R7
  AST_CANCEL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> !tbl_we);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !tbl_we));  // R8
endmodule

bind ptr_refill_engine ptr_refill_chk #(
  .NUM_TABLES(NUM_TABLES), .TBL_W(TBL_W), .TBL_H(TBL_H), .XW(XW), .YW(YW), .TW(TW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .tbl_we        (tbl_we),
  .tbl_id        (tbl_id),
  .tbl_x         (tbl_x),
  .tbl_y         (tbl_y),
  .busy          (busy),
  .cancel_evt    (cancel_evt),
  .done_evt      (done_evt),
  .err_evt       (err_evt),
  .irq_st        (irq_st)
);

// File: tb/ptr_refill_engine_tb.sv
`timescale 1ns/1ps
module ptr_refill_engine_tb;
  localparam int NT = 2, TW_ = 96, TH_ = 64, AW = 5;
  localparam int XW = 7, YW = 6, TW = 1;

  typedef struct packed {
    logic [15:0] x0; logic [15:0] y0; logic [15:0] x1; logic [15:0] y1; logic [3:0] tid;
  } area_t;
  localparam int NV = 6;
  localparam area_t VEC [NV] = '{
    '{16'd0,  16'd0,  16'd0,  16'd0,  4'd0},
    '{16'd3,  16'd2,  16'd6,  16'd2,  4'd1},
    '{16'd10, 16'd5,  16'd12, 16'd7,  4'd0},
    '{16'd95, 16'd63, 16'd95, 16'd63, 4'd1},
    '{16'd0,  16'd0,  16'd3,  16'd3,  4'd1},
    '{16'd90, 16'd60, 16'd95, 16'd61, 4'd0}
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data, tbl_data;
  logic tbl_we;
  logic [TW-1:0] tbl_id;
  logic [XW-1:0] tbl_x;
  logic [YW-1:0] tbl_y;

  always #2 clk = ~clk;

  ptr_refill_engine #(.NUM_TABLES(NT), .TBL_W(TW_), .TBL_H(TH_), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .tbl_we(tbl_we),
    .tbl_id(tbl_id), .tbl_x(tbl_x), .tbl_y(tbl_y), .tbl_data(tbl_data));

  logic [31:0] mem [0:1023];
  logic [31:0] cyc = 0;
  int wcnt = 0, rcnt = 0;
  logic [31:0] lg_d [0:255];
  logic [XW-1:0] lg_x [0:255];
  logic [YW-1:0] lg_y [0:255];
  logic [TW-1:0] lg_t [0:255];
  logic [31:0] lg_a [0:255];
  int nchk = 0, nfail = 0;

  assign mem_req_ready = (cyc % 3) != 2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_rsp_valid <= 1'b0;
    else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[11:2]];
        if (rcnt < 256) lg_a[rcnt] <= mem_req_addr;
        rcnt <= rcnt + 1;
      end
      if (tbl_we) begin
        if (wcnt < 256) begin
          lg_d[wcnt] <= tbl_data; lg_x[wcnt] <= tbl_x;
          lg_y[wcnt] <= tbl_y;    lg_t[wcnt] <= tbl_id;
        end
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(5'd4, s);
      if (s[0]) return;
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] nxt, input area_t a, input logic [31:0] dptr);
    mem[base/4 + 0] = nxt;
    mem[base/4 + 1] = {a.y0, a.x0};
    mem[base/4 + 2] = {a.y1, a.x1};
    mem[base/4 + 3] = {28'hABCDEF0, a.tid};
    mem[base/4 + 4] = dptr;
  endtask

  task automatic clear_logs();
    @(negedge clk); wcnt = 0; rcnt = 0;
  endtask

  // verifies entries [first .. first+n-1] against area a and data at dbase
  task automatic check_area(input int first, input area_t a, input int dbase, input string tag);
    int w, n, bad;
    w = int'(a.x1) - int'(a.x0) + 1;
    n = w * (int'(a.y1) - int'(a.y0) + 1);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      if (32'(lg_x[first+k]) != 32'(int'(a.x0) + k % w) ||
          32'(lg_y[first+k]) != 32'(int'(a.y0) + k / w) ||
          32'(lg_t[first+k]) != 32'(a.tid) ||
          lg_d[first+k] != mem[dbase/4 + k]) bad++;
    end
    check(bad == 0, tag, 32'(bad), 32'd0);
  endtask

  logic [31:0] v, v2;
  int n_exp, c0;
  logic seen;

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h5000_0000 + 32'(i) * 32'h0001_0003;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(5'd4, v);  check(v == 32'h1, "R1 status", v, 32'h1);
    reg_read(5'd8, v);  check(v == 32'h0, "R1 irq status", v, 32'h0);
    reg_read(5'd12, v); check(v == 32'h0, "R1 irq enable", v, 32'h0);
    check(!irq && !mem_req_valid, "R1 irq/req idle", {30'd0, irq, mem_req_valid}, 32'd0);

    // R2 identification registers
    reg_read(5'd16, v); check(v == 32'h0102_0000, "R2 hwinfo", v, 32'h0102_0000);
    reg_read(5'd20, v); check(v == 32'h0203_0000, "R2 geometry", v, 32'h0203_0000);
    reg_write(5'd16, 32'hFFFF_FFFF); reg_write(5'd20, 32'hFFFF_FFFF);
    reg_read(5'd16, v); reg_read(5'd20, v2);
    check(v == 32'h0102_0000 && v2 == 32'h0203_0000, "R2 read-only", v ^ v2, 32'h0301_0000);

    // R4/R5 vector table: one descriptor per vector
    for (int i = 0; i < NV; i++) begin
      reg_write(5'd8, 32'hFF);
      put_desc(32'h040, 32'h0, VEC[i], 32'h200);
      clear_logs();
      reg_write(5'd0, 32'h040);
      wait_ready();
      n_exp = (int'(VEC[i].x1) - int'(VEC[i].x0) + 1) * (int'(VEC[i].y1) - int'(VEC[i].y0) + 1);
      check(wcnt == n_exp, "R4 entry count", 32'(wcnt), 32'(n_exp));
      check_area(0, VEC[i], 32'h200, "R4 raster order/data/table");
      reg_read(5'd8, v); check(v == 32'h2, "R5 list done", v, 32'h2);
      reg_read(5'd4, v); check(v == 32'h1, "R5 ready after chain", v, 32'h1);
    end

    // R3/R5 two-descriptor chain with junk in pointer low bits
    reg_write(5'd8, 32'hFF);
    put_desc(32'h100, 32'h149, '{16'd0, 16'd0, 16'd1, 16'd0, 4'd0}, 32'h305);
    put_desc(32'h140, 32'h0,   '{16'd5, 16'd5, 16'd5, 16'd6, 4'd1}, 32'h320);
    clear_logs();
    reg_write(5'd0, 32'h10C);
    wait_ready();
    check(wcnt == 4, "R5 chain entry count", 32'(wcnt), 32'd4);
    check_area(0, '{16'd0, 16'd0, 16'd1, 16'd0, 4'd0}, 32'h300, "R4 chain first area");
    check_area(2, '{16'd5, 16'd5, 16'd5, 16'd6, 4'd1}, 32'h320, "R5 chain second area");
    check(rcnt == 14, "R3 read count", 32'(rcnt), 32'd14);
    c0 = 0;
    for (int k = 0; k < 5; k++) begin
      if (lg_a[k] != 32'h100 + 32'(4*k)) c0++;
      if (lg_a[7+k] != 32'h140 + 32'(4*k)) c0++;
    end
    if (lg_a[5] != 32'h300 || lg_a[6] != 32'h304 || lg_a[12] != 32'h320 || lg_a[13] != 32'h324) c0++;
    check(c0 == 0, "R3 fetch addresses", 32'(c0), 32'd0);
    reg_read(5'd8, v); check(v == 32'h2, "R5 chain list done", v, 32'h2);

    // R6 interrupt masking and write-one-to-clear
    check(!irq, "R6 irq masked", {31'd0, irq}, 32'd0);
    reg_write(5'd12, 32'h7E); #1;
    check(irq, "R6 irq enabled", {31'd0, irq}, 32'd1);
    reg_write(5'd8, 32'h01); reg_read(5'd8, v);
    check(v == 32'h2 && irq, "R6 other bit w1c keeps", v, 32'h2);
    reg_write(5'd8, 32'h02); reg_read(5'd8, v);
    check(v == 32'h0 && !irq, "R6 w1c clears", {v[30:0], irq}, 32'h0);

    // R7 illegal descriptors
    begin
      area_t bad [3];
      bad[0] = '{16'd4, 16'd0, 16'd2, 16'd0, 4'd0};
      bad[1] = '{16'd0, 16'd0, 16'd1, 16'd1, 4'd2};
      bad[2] = '{16'd0, 16'd60, 16'd0, 16'd64, 4'd1};
      for (int i = 0; i < 3; i++) begin
        put_desc(32'h080, 32'h0, bad[i], 32'h200);
        clear_logs();
        reg_write(5'd0, 32'h080);
        wait_ready();
        reg_read(5'd4, v);
        check(v == 32'h3, "R7 err status", v, 32'h3);
        reg_read(5'd8, v);
        check(v == 32'h0 && wcnt == 0, "R7 no writes no lst", v | 32'(wcnt), 32'h0);
      end
      put_desc(32'h080, 32'h0, VEC[0], 32'h200);
      reg_write(5'd0, 32'h080);
      wait_ready();
      reg_read(5'd4, v); check(v == 32'h1, "R7 err cleared on start", v, 32'h1);
      reg_write(5'd8, 32'hFF);
    end

    // R9 start while busy is ignored
    put_desc(32'h180, 32'h0, '{16'd0, 16'd0, 16'd15, 16'd3, 4'd0}, 32'h400);
    put_desc(32'h1C0, 32'h0, VEC[0], 32'h200);
    clear_logs();
    reg_write(5'd0, 32'h180);
    repeat (10) @(negedge clk);
    reg_write(5'd0, 32'h1C0);
    wait_ready();
    check(wcnt == 64, "R9 running chain intact", 32'(wcnt), 32'd64);
    seen = 0;
    for (int k = 0; k < rcnt && k < 256; k++) if (lg_a[k] >= 32'h1C0 && lg_a[k] < 32'h1E0) seen = 1;
    check(!seen, "R9 late pointer not fetched", {31'd0, seen}, 32'd0);

    // R8 cancel mid-walk
    reg_write(5'd8, 32'hFF);
    clear_logs();
    reg_write(5'd0, 32'h180);
    repeat (40) @(negedge clk);
    reg_write(5'd0, 32'h0);
    wait_ready();
    c0 = wcnt;
    check(c0 > 0 && c0 < 64, "R8 partial fill", 32'(c0), 32'd32);
    repeat (50) @(negedge clk);
    check(wcnt == c0, "R8 no writes after cancel", 32'(wcnt), 32'(c0));
    reg_read(5'd8, v); check(v == 32'h0, "R8 no list done", v, 32'h0);
    reg_read(5'd4, v); check(v == 32'h1, "R8 ready after cancel", v, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule